// File: doc/BRIEF.md
# Ternary Five-Tuple Packet Filter

This block sits inline on a 32-bit IPv4 word stream that carries start, end and valid flags. For each packet it builds a 104-bit lookup key from the plain 20-byte header and the following transport port word. The key holds the source address, destination address, source port, destination port and protocol. It compares the key in parallel against two value/mask entries. A packet that hits either entry is not removed from the stream. Its time-to-live byte is cleared in flight, and its header checksum is patched incrementally so the header stays consistent. Every packet, rejected or not, leaves the block after the same fixed delay.

The entries are written in-band. A UDP packet sent to a fixed address and port carries, in its payload, an entry number followed by a value and a mask. The new entry takes effect when that packet ends, and the packet itself is forwarded untouched. The header words of a packet (words 0 to 5, counted from the start flag) are expected on consecutive cycles. There is no backpressure.

Top module: `pkt_tuple_filter`

## Requirements
- R1: Every input word appears at the output exactly 4 clock cycles after it is accepted, with its valid, start and end flags, and in the same order. Every word except word 2 of a rejected packet leaves unchanged.
- R2: The key is {word 3 (source IP), word 4 (destination IP), word 5 bits 31:16 (source port), word 5 bits 15:0 (destination port), word 2 bits 23:16 (protocol)}, with the source IP at the most significant end. An entry hits when the key equals the entry value in every bit where its mask is 1. Mask bits at 0 are ignored, so a programmed all-zero mask hits every packet.
- R3: A packet that hits entry 0, entry 1 or both leaves with word 2 bits 31:24 (the time-to-live) set to zero and bits 23:16 (the protocol) unchanged.
- R4: In a rejected packet, word 2 bits 15:0 carry the header checksum a full recomputation would give for the header with time-to-live zero. A packet whose time-to-live is already zero keeps its checksum.
- R5: While reset is held, out_valid is low. After reset both entries are empty, and no packet is altered until an entry has been written.
- R6: A control packet has destination IP 0xC0A81E0D (192.168.30.13), protocol 17 and destination port 800. It is forwarded unchanged, even when an entry matches its key.
- R7: In a control packet, word 7 is the entry number: 0 or 1 writes that entry, and any other value writes nothing. Words 8 to 11 form a 128-bit value, with word 8 most significant and the key in the low 104 bits. Words 12 to 15 form the mask in the same way. The write takes effect after the packet's last word and is already used for a packet that follows with no idle cycle.
- R8: A control packet whose last word comes before word 15 leaves both entries unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | Input word is the first of a packet |
| in_eop | input | 1 | Input word is the last of a packet |
| in_data | input | 32 | Input packet word |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | Output word is the first of a packet |
| out_eop | output | 1 | Output word is the last of a packet |
| out_data | output | 32 | Output packet word, time-to-live and checksum patched on rejection |

## Verification
Two decisions are made on the same edge, when the port word (word 5) of a packet arrives: the block decides whether the packet is a control packet, and it decides whether the packet hits an entry. The bench forces both at once. It first programs an entry whose value is the control destination, protocol and port. It then sends a control packet that hits this entry. The TTL and checksum of that packet must be forwarded unchanged, and the table must still take its payload. A data packet follows with no idle cycle, and it must already be judged against the freshly written entry.

// File: rtl/pkt_filter_pkg.sv
package pkt_filter_pkg;

  localparam int WORD_W = 32;
  localparam int KEY_W  = 104;

  // word positions inside a packet, counted from the start word
  localparam int W_TTL   = 2;
  localparam int W_SRC   = 3;
  localparam int W_DST   = 4;
  localparam int W_PORTS = 5;
  localparam int W_INDEX = 7;
  localparam int W_VAL0  = 8;
  localparam int W_MSK0  = 12;
  localparam int W_LAST  = 15;

  localparam logic [7:0] PROTO_UDP = 8'd17;

  typedef logic [KEY_W-1:0] key_t;

  typedef struct packed {
    logic              valid;
    logic              sop;
    logic              eop;
    logic              ttl_word;
    logic [WORD_W-1:0] data;
  } beat_t;

  // one's-complement patch of a 16-bit header checksum when one header
  // half-word changes from old_hw to new_hw
  function automatic logic [15:0] csum_patch(logic [15:0] hc,
                                             logic [15:0] old_hw,
                                             logic [15:0] new_hw);
    logic [17:0] acc;
    acc = {2'b00, ~hc} + {2'b00, ~old_hw} + {2'b00, new_hw};
    acc = {2'b00, acc[15:0]} + {16'h0000, acc[17:16]};
    acc = {2'b00, acc[15:0]} + {16'h0000, acc[17:16]};
    return ~acc[15:0];
  endfunction

  // clear the time-to-live byte of header word 2 and repair its checksum
  function automatic logic [31:0] kill_ttl(logic [31:0] w);
    return {8'h00, w[23:16], csum_patch(w[15:0], w[31:16], {8'h00, w[23:16]})};
  endfunction

endpackage

// File: rtl/tuple_cam.sv
module tuple_cam
  import pkt_filter_pkg::*;
#(
  parameter int N_ENTRIES = 2,
  parameter int IDX_W     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  key_t             wr_val,
  input  key_t             wr_mask,
  input  key_t             key,
  output logic             hit
);

  key_t                 val_q  [N_ENTRIES];
  key_t                 msk_q  [N_ENTRIES];
  logic [N_ENTRIES-1:0] used_q;
  logic [N_ENTRIES-1:0] hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      for (int e = 0; e < N_ENTRIES; e++) begin
        val_q[e] <= '0;
        msk_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < N_ENTRIES; e++) begin
        if (wr_en && (wr_idx == IDX_W'(e))) begin
          val_q[e]  <= wr_val;
          msk_q[e]  <= wr_mask;
          used_q[e] <= 1'b1;
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_ENTRIES; g++) begin : g_cmp
      assign hits[g] = used_q[g] && (((key ^ val_q[g]) & msk_q[g]) == '0);
    end
  endgenerate

  assign hit = |hits;

endmodule

// File: rtl/ctl_loader.sv
module ctl_loader
  import pkt_filter_pkg::*;
#(
  parameter int N_ENTRIES = 2,
  parameter int IDX_W     = 1,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_eop,
  input  logic [31:0]      in_data,
  input  logic [CNT_W-1:0] widx,
  input  logic             ctl_pkt,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output key_t             wr_val,
  output key_t             wr_mask
);

  localparam int STAGE_W = 4 * WORD_W;

  logic [31:0]        idx_q,    idx_d;
  logic [STAGE_W-1:0] val_q,    val_d;
  logic [STAGE_W-1:0] msk_q,    msk_d;
  logic               commit_q, commit_d;
  logic               take;
  logic [1:0]         vslot, mslot;
  logic [23:0]        pad_unused;

  assign take  = in_valid && ctl_pkt;
  assign vslot = 2'(widx - CNT_W'(W_VAL0));
  assign mslot = 2'(widx - CNT_W'(W_MSK0));

  always_comb begin
    idx_d = idx_q;
    val_d = val_q;
    msk_d = msk_q;
    if (take) begin
      if (widx == CNT_W'(W_INDEX))
        idx_d = in_data;
      if ((widx >= CNT_W'(W_VAL0)) && (widx < CNT_W'(W_MSK0)))
        val_d[{~vslot, 5'd0} +: 32] = in_data;
      if ((widx >= CNT_W'(W_MSK0)) && (widx <= CNT_W'(W_LAST)))
        msk_d[{~mslot, 5'd0} +: 32] = in_data;
    end
    commit_d = take && in_eop && (widx >= CNT_W'(W_LAST)) &&
               (idx_d < 32'(N_ENTRIES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      val_q    <= '0;
      msk_q    <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= commit_d;
      if (take) begin
        idx_q <= idx_d;
        val_q <= val_d;
        msk_q <= msk_d;
      end
    end
  end

  assign wr_en      = commit_q;
  assign wr_idx     = idx_q[IDX_W-1:0];
  assign wr_val     = val_q[KEY_W-1:0];
  assign wr_mask    = msk_q[KEY_W-1:0];
  assign pad_unused = val_q[STAGE_W-1:KEY_W] ^ msk_q[STAGE_W-1:KEY_W];

endmodule

// File: rtl/ttl_delay_line.sv
module ttl_delay_line
  import pkt_filter_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int REWRITE_AT = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  beat_t beat_in,
  input  logic  rewrite,
  output beat_t beat_out
);

  beat_t stg_q [DEPTH];
  beat_t stg_d [DEPTH];

  always_comb begin
    stg_d[0] = beat_in;
    for (int i = 1; i < DEPTH; i++) begin
      stg_d[i] = stg_q[i-1];
      if ((i == REWRITE_AT) && rewrite && stg_q[i-1].valid && stg_q[i-1].ttl_word)
        stg_d[i].data = kill_ttl(stg_q[i-1].data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign beat_out = stg_q[DEPTH-1];

endmodule

// File: rtl/pkt_tuple_filter.sv
module pkt_tuple_filter
  import pkt_filter_pkg::*;
#(
  parameter int          N_ENTRIES = 2,
  parameter int          CNT_W     = 5,
  parameter logic [31:0] CTL_IP    = 32'hC0A8_1E0D,
  parameter logic [15:0] CTL_PORT  = 16'd800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic        out_sop,
  output logic        out_eop,
  output logic [31:0] out_data
);

  localparam int IDX_W      = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam int REWRITE_AT = W_PORTS - W_TTL;
  localparam int DEPTH      = REWRITE_AT + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // word position inside the current packet
  logic [CNT_W-1:0] cnt_q, cnt_d, widx;

  assign widx = in_sop ? '0 : cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (in_valid) begin
      if (in_sop)              cnt_d = CNT_W'(1);
      else if (cnt_q != '1)    cnt_d = cnt_q + 1'b1;
    end
  end

  // header field capture
  logic [7:0]  proto_q, proto_d;
  logic [31:0] src_q,   src_d;
  logic [31:0] dst_q,   dst_d;
  logic        ctl_q,   ctl_d;
  logic        port_word, ctl_now, cam_hit, rewrite;
  key_t        key;

  assign port_word = in_valid && (widx == CNT_W'(W_PORTS));
  assign key       = {src_q, dst_q, in_data[31:16], in_data[15:0], proto_q};
  assign ctl_now   = (dst_q == CTL_IP) && (proto_q == PROTO_UDP) &&
                     (in_data[15:0] == CTL_PORT);
  assign rewrite   = port_word && cam_hit && !ctl_now;

  always_comb begin
    proto_d = proto_q;
    src_d   = src_q;
    dst_d   = dst_q;
    ctl_d   = ctl_q;
    if (in_valid) begin
      if (widx == CNT_W'(W_TTL)) proto_d = in_data[23:16];
      if (widx == CNT_W'(W_SRC)) src_d   = in_data;
      if (widx == CNT_W'(W_DST)) dst_d   = in_data;
      if (in_sop)                ctl_d   = 1'b0;
      else if (port_word)        ctl_d   = ctl_now;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q   <= '0;
      proto_q <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      ctl_q   <= 1'b0;
    end else if (in_valid) begin
      cnt_q   <= cnt_d;
      proto_q <= proto_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      ctl_q   <= ctl_d;
    end
  end

  // table programming
  logic             tbl_wr_en;
  logic [IDX_W-1:0] tbl_wr_idx;
  key_t             tbl_wr_val, tbl_wr_mask;

  ctl_loader #(
    .N_ENTRIES (N_ENTRIES),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_loader (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .in_valid(in_valid),
    .in_eop  (in_eop),
    .in_data (in_data),
    .widx    (widx),
    .ctl_pkt (ctl_q),
    .wr_en   (tbl_wr_en),
    .wr_idx  (tbl_wr_idx),
    .wr_val  (tbl_wr_val),
    .wr_mask (tbl_wr_mask)
  );

  tuple_cam #(
    .N_ENTRIES (N_ENTRIES),
    .IDX_W     (IDX_W)
  ) u_cam (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (tbl_wr_en),
    .wr_idx (tbl_wr_idx),
    .wr_val (tbl_wr_val),
    .wr_mask(tbl_wr_mask),
    .key    (key),
    .hit    (cam_hit)
  );

  // word stream delay with in-flight rewrite
  beat_t beat_in, beat_out;

  assign beat_in.valid    = in_valid;
  assign beat_in.sop      = in_valid && in_sop;
  assign beat_in.eop      = in_valid && in_eop;
  assign beat_in.ttl_word = in_valid && (widx == CNT_W'(W_TTL));
  assign beat_in.data     = in_data;

  ttl_delay_line #(
    .DEPTH      (DEPTH),
    .REWRITE_AT (REWRITE_AT)
  ) u_delay (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .beat_in (beat_in),
    .rewrite (rewrite),
    .beat_out(beat_out)
  );

  logic ttl_flag_unused;
  assign ttl_flag_unused = beat_out.ttl_word;

  assign out_valid = beat_out.valid;
  assign out_sop   = beat_out.sop;
  assign out_eop   = beat_out.eop;
  assign out_data  = beat_out.data;

endmodule

// File: rtl/pkt_tuple_filter_checks.sv
module pkt_tuple_filter_checks (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        in_valid,
  input logic        in_sop,
  input logic        in_eop,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic        out_sop,
  input logic [31:0] out_data,
  input logic        tbl_wr_en,
  input logic        cam_hit
);

  logic [2:0] warm_q;
  logic       any_wr_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      warm_q   <= '0;
      any_wr_q <= 1'b0;
    end else begin
      if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
      if (tbl_wr_en)      any_wr_q <= 1'b1;
    end
  end

  assert_fixed_latency_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (warm_q >= 3'd5) |->
      ((out_valid == $past(in_valid, 4)) && (out_sop == $past(in_valid && in_sop, 4))));

  assert_sop_has_valid_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_sop |-> out_valid);

  assert_only_ttl_cleared_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((warm_q >= 3'd5) && out_valid && (out_data != $past(in_data, 4))) |->
      ((out_data[31:24] == 8'h00) && (out_data[23:16] == $past(in_data[23:16], 4))));

  assert_empty_table_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !any_wr_q |-> !cam_hit);

  assert_write_after_last_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((warm_q >= 3'd1) && tbl_wr_en) |-> $past(in_valid && in_eop));

endmodule

bind pkt_tuple_filter pkt_tuple_filter_checks u_checks (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .in_valid  (in_valid),
  .in_sop    (in_sop),
  .in_eop    (in_eop),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .out_data  (out_data),
  .tbl_wr_en (tbl_wr_en),
  .cam_hit   (cam_hit)
);

// File: tb/test_pkt_tuple_filter.sv
module test_pkt_tuple_filter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_eop;
  logic [31:0] in_data;
  logic        out_valid, out_sop, out_eop;
  logic [31:0] out_data;

  always #10 clk = ~clk;

  pkt_tuple_filter i_pkt_tuple_filter (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  localparam logic [31:0] CTL_DST = 32'hC0A8_1E0D;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] sp;
    logic [15:0] dp;
    logic [7:0]  proto;
    logic [7:0]  ttl;
    logic        hit;
  } vec_t;

  // entry 0: destination 10.0.0.7 exact; entry 1: protocol 6 and port 22
  localparam vec_t VECS [9] = '{
    '{32'h0102_0304, 32'h0A00_0007, 16'h1000, 16'h0050, 8'd17, 8'd64, 1'b1},
    '{32'h0102_0304, 32'h0A00_0008, 16'h1000, 16'd23,   8'd6,  8'd64, 1'b0},
    '{32'h0102_0304, 32'h0A00_0008, 16'h1000, 16'd22,   8'd6,  8'd64, 1'b1},
    '{32'h0102_0304, 32'h0A00_0008, 16'h1000, 16'd22,   8'd17, 8'd64, 1'b0},
    '{32'h0505_0505, 32'h0A00_0007, 16'h2222, 16'd22,   8'd6,  8'd1,  1'b1},
    '{32'h0102_0304, 32'h0A00_0007, 16'h1000, 16'h0050, 8'd17, 8'd0,  1'b1},
    '{32'hFFFF_FFFF, 32'h0A00_0007, 16'h0000, 16'h0000, 8'd1,  8'd255,1'b1},
    '{32'h0102_0304, 32'h0B00_0007, 16'hFFFF, 16'd22,   8'd6,  8'd128,1'b1},
    '{32'h0102_0304, 32'h0A00_0006, 16'h1000, 16'd21,   8'd6,  8'd64, 1'b0}
  };

  int checks = 0;
  int errors = 0;
  int wr_ptr = 0;
  int rd_ptr = 0;
  int cyc    = 0;

  logic [31:0] exp_data [0:2047];
  logic        exp_sop  [0:2047];
  logic        exp_eop  [0:2047];
  string       exp_tag  [0:2047];

  function automatic logic [15:0] ip_csum(logic [31:0] w0, logic [31:0] w1,
                                          logic [31:0] w2, logic [31:0] w3,
                                          logic [31:0] w4);
    logic [31:0] s;
    s = 32'(w0[31:16]) + 32'(w0[15:0]) + 32'(w1[31:16]) + 32'(w1[15:0]) +
        32'(w2[31:16]) + 32'(w3[31:16]) + 32'(w3[15:0]) +
        32'(w4[31:16]) + 32'(w4[15:0]);
    s = (s & 32'h0000_FFFF) + (s >> 16);
    s = (s & 32'h0000_FFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  function automatic logic [103:0] mk_key(logic [31:0] s, logic [31:0] d,
                                          logic [15:0] sp, logic [15:0] dp,
                                          logic [7:0] pr);
    return {s, d, sp, dp, pr};
  endfunction

  task automatic push_exp(logic [31:0] d, logic s, logic e, string tag);
    exp_data[wr_ptr] = d;
    exp_sop[wr_ptr]  = s;
    exp_eop[wr_ptr]  = e;
    exp_tag[wr_ptr]  = tag;
    wr_ptr++;
  endtask

  task automatic drive(logic [31:0] d, logic s, logic e);
    @(negedge clk);
    in_valid = 1'b1;
    in_sop   = s;
    in_eop   = e;
    in_data  = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
      in_eop   = 1'b0;
      in_data  = 32'h0;
    end
  endtask

  task automatic send_pkt(logic [31:0] src, logic [31:0] dst, logic [15:0] sp,
                          logic [15:0] dp, logic [7:0] proto, logic [7:0] ttl,
                          logic hit, string tag);
    logic [31:0] w [8];
    logic [31:0] w2x;
    w[0] = {8'h45, 8'h00, 16'd32};
    w[1] = 32'h1C46_4000;
    w[3] = src;
    w[4] = dst;
    w[2] = {ttl, proto, ip_csum(w[0], w[1], {ttl, proto, 16'h0}, w[3], w[4])};
    w[5] = {sp, dp};
    w[6] = {16'd12, 16'h0000};
    w[7] = 32'hA5A5_0000 | 32'(wr_ptr);
    w2x  = {8'h00, proto, ip_csum(w[0], w[1], {8'h00, proto, 16'h0}, w[3], w[4])};
    for (int k = 0; k < 8; k++) begin
      drive(w[k], k == 0, k == 7);
      if (k == 2 && hit) push_exp(w2x, 1'b0, 1'b0, {tag, " R3 R4 rejected header"});
      else               push_exp(w[k], k == 0, k == 7, {tag, " word pass"});
    end
  endtask

  task automatic send_ctl(logic [31:0] idx, logic [103:0] val, logic [103:0] msk,
                          int nwords, string tag);
    logic [31:0]  w [18];
    logic [127:0] v, m;
    v = {24'h0, val};
    m = {24'h0, msk};
    w[0] = {8'h45, 8'h00, 16'(nwords * 4)};
    w[1] = 32'h0BAD_0000;
    w[3] = 32'h0A0A_0A0A;
    w[4] = CTL_DST;
    w[2] = {8'd32, 8'd17, ip_csum(w[0], w[1], {8'd32, 8'd17, 16'h0}, w[3], w[4])};
    w[5] = {16'd1234, 16'd800};
    w[6] = {16'((nwords - 5) * 4), 16'h0000};
    w[7] = idx;
    for (int k = 0; k < 4; k++) begin
      w[8 + k]  = v[127 - 32*k -: 32];
      w[12 + k] = m[127 - 32*k -: 32];
    end
    w[16] = 32'h0;
    w[17] = 32'h0;
    for (int k = 0; k < nwords; k++) begin
      drive(w[k], k == 0, k == nwords - 1);
      push_exp(w[k], k == 0, k == nwords - 1, {tag, " R6 control forwarded unchanged"});
    end
  endtask

  // output monitor: every word is compared in order
  always @(negedge clk) begin
    if (out_valid) begin
      checks++;
      if (rd_ptr >= wr_ptr) begin
        errors++;
        $display("FAIL R1 unexpected word: actual %h expected none", out_data);
      end else begin
        if (out_data !== exp_data[rd_ptr] || out_sop !== exp_sop[rd_ptr] ||
            out_eop !== exp_eop[rd_ptr]) begin
          errors++;
          $display("FAIL %s word %0d: actual %h sop %b eop %b expected %h sop %b eop %b",
                   exp_tag[rd_ptr], rd_ptr, out_data, out_sop, out_eop,
                   exp_data[rd_ptr], exp_sop[rd_ptr], exp_eop[rd_ptr]);
        end
        rd_ptr++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
    in_data  = 32'h0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R5 reset: actual out_valid %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    idle(4);

    // R5: empty table, even a broad packet passes untouched
    send_pkt(32'h0102_0304, 32'h0A00_0007, 16'h1000, 16'd22, 8'd6, 8'd64, 1'b0, "R5");
    idle(6);

    // R7: program both entries
    send_ctl(32'd0, mk_key(32'h0, 32'h0A00_0007, 16'h0, 16'h0, 8'h0),
             mk_key(32'h0, 32'hFFFF_FFFF, 16'h0, 16'h0, 8'h0), 16, "R7");
    send_ctl(32'd1, mk_key(32'h0, 32'h0, 16'h0, 16'd22, 8'd6),
             mk_key(32'h0, 32'h0, 16'h0, 16'hFFFF, 8'hFF), 16, "R7");
    idle(3);

    // R2 R3 R4: vector walk, back to back
    for (int v = 0; v < 9; v++)
      send_pkt(VECS[v].src, VECS[v].dst, VECS[v].sp, VECS[v].dp, VECS[v].proto,
               VECS[v].ttl, VECS[v].hit, "R2");
    idle(6);

    // R7: an out-of-range entry number writes nothing
    send_ctl(32'd2, mk_key(32'h0, 32'h0A00_0009, 16'h0, 16'h0, 8'h0),
             mk_key(32'h0, 32'hFFFF_FFFF, 16'h0, 16'h0, 8'h0), 16, "R7");
    send_pkt(32'h0102_0304, 32'h0A00_0009, 16'h1000, 16'd80, 8'd17, 8'd64, 1'b0, "R7 bad index");
    idle(4);

    // R8: a control packet cut short writes nothing; entry 1 keeps its rule
    send_ctl(32'd1, mk_key(32'h0, 32'h0A00_0009, 16'h0, 16'h0, 8'h0),
             mk_key(32'h0, 32'hFFFF_FFFF, 16'h0, 16'h0, 8'h0), 15, "R8");
    send_pkt(32'h0102_0304, 32'h0A00_0009, 16'h1000, 16'd80, 8'd17, 8'd64, 1'b0, "R8 short");
    send_pkt(32'h0102_0304, 32'h0A00_0008, 16'h1000, 16'd22, 8'd6, 8'd64, 1'b1, "R8 kept");
    idle(4);

    // R6: entry 0 made to hit control traffic, then control and lookup collide
    send_ctl(32'd0, mk_key(32'h0, CTL_DST, 16'h0, 16'd800, 8'd17),
             mk_key(32'h0, 32'hFFFF_FFFF, 16'h0, 16'hFFFF, 8'hFF), 16, "R6");
    send_ctl(32'd1, mk_key(32'h0, 32'h0A00_0009, 16'h0, 16'h0, 8'h0),
             mk_key(32'h0, 32'hFFFF_FFFF, 16'h0, 16'h0, 8'h0), 18, "R6");
    send_pkt(32'h0102_0304, 32'h0A00_0009, 16'h1000, 16'd80, 8'd17, 8'd64, 1'b1, "R7 no gap");
    send_pkt(32'h0102_0304, 32'h0A00_0008, 16'h1000, 16'd22, 8'd6, 8'd64, 1'b0, "R7 replaced");
    idle(4);

    // R2: a programmed all-zero mask hits anything
    send_ctl(32'd0, mk_key(32'h1, 32'h2, 16'h3, 16'h4, 8'h5), 104'h0, 16, "R2");
    send_pkt(32'h7777_0001, 32'h0808_0808, 16'h0101, 16'h0202, 8'd50, 8'd9, 1'b1, "R2 zero mask");
    idle(10);

    checks++;
    if (rd_ptr != wr_ptr) begin
      errors++;
      $display("FAIL R1 word count: actual %0d expected %0d", rd_ptr, wr_ptr);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule